// File: doc/BRIEF.md
# Two-Stage Clock Recovery Lock Sequencer

This block supervises a clock recovery loop built around one oscillator that must first be pulled to the right frequency and only then be phase-aligned to the incoming data. It runs on the reference clock and also receives the oscillator's feedback clock. It counts feedback edges over fixed windows of reference cycles and compares each count with the window length times the divide ratio `div_ratio`. This lets the reference run `div_ratio` times slower than the oscillator.

A run of good windows ends frequency acquisition. The sequencer then drops the frequency-loop enable and holds both loop enables low for a programmable quiet time, so the oscillator control line is not disturbed during the switch. After that it enables the phase loop and reports lock. If the phase detector reports lost lock, or the frequency drifts away for a run of windows, control returns to the frequency loop. Frequency must then be acquired again before the phase loop is re-enabled.

Edge counts cross from the feedback domain through a toggle request/acknowledge handshake with two-flop synchronizers. A snapshot of a free-running counter is taken on each request, and the difference of successive snapshots is the window count.

Top module: `freq_phase_lock_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `status` is 0, `freq_en` is 1, and `phase_en` and `locked` are 0.
- R2: With the feedback clock at exactly `div_ratio` times the reference rate, the block reaches `status` 2 within (HIT_RUN+2)*WIN_LEN + `blank_len` + 16 reference cycles of leaving reset.
- R3: `freq_en` and `phase_en` are never high together. State codes on `status`: 0 means frequency acquisition, with only `freq_en` high. 1 means handover, with both enables low. 2 means phase tracking, with `phase_en` and `locked` high. Code 3 never appears.
- R4: `status` only moves 0 to 1, 1 to 2, or 2 to 0.
- R5: Frequency lock needs HIT_RUN consecutive matching windows. The first window after reset is discarded, so `status` is still 0 at (HIT_RUN+1)*WIN_LEN - 1 cycles after reset.
- R6: When `phase_lost` is high during phase tracking, `status` becomes 0 and `freq_en` becomes 1 after the third rising reference edge.
- R7: Handover lasts exactly `blank_len` reference cycles, counted at the moment handover is entered. A value of 0 acts as 1.
- R8: `phase_lost` has no effect during frequency acquisition or handover.
- R9: During phase tracking, MISS_RUN consecutive mismatching windows return `status` to 0. A single window does not.
- R10: A window matches when the count differs from WIN_LEN*`div_ratio` by at most `tol`. A clock that is 2 counts off locks, and one that is 12 counts off never locks.
- R11: The expected count scales with `div_ratio`. Changing it without changing the clock drops lock, and a feedback clock at the new ratio locks again.
- R12: After a `phase_lost` exit, frequency lock is required afresh: `status` stays 0 for at least (HIT_RUN-1)*WIN_LEN - 2 cycles, then locks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the controller's clock |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| fb_clk | input | 1 | Oscillator feedback clock being measured |
| div_ratio | input | M_W | Expected feedback-to-reference frequency ratio |
| tol | input | TOL_W | Allowed count error per window |
| blank_len | input | BL_W | Handover quiet time in reference cycles |
| phase_lost | input | 1 | Loss-of-phase-lock indication (asynchronous) |
| freq_en | output | 1 | Enable for the frequency tracking loop |
| phase_en | output | 1 | Enable for the phase tracking loop |
| locked | output | 1 | High while in phase tracking |
| status | output | 2 | State code: 0 acquire, 1 handover, 2 track |

## Verification
The feedback clock is driven at four rates. The first is an exact multiple of the reference, which must lock. The second is a few counts off but inside the tolerance, which must still lock. The third is far off, which must drop lock after the miss run and never lock again. The fourth is at a new divide ratio, which shows that the expected count follows `div_ratio` and not a fixed constant. Phase-lost pulses are placed in tracking, in acquisition and in the middle of a handover, which separates the one state where the indication must act from the two where it must be ignored. Two different quiet times confirm that the handover length comes from the programmed value at entry.

// File: rtl/lock_ctrl_pkg.sv
`timescale 1ns/1ps
package lock_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_HAND  = 2'd1,
    ST_TRACK = 2'd2
  } lock_state_t;
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer, one chain per bit.
module bit_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_chain
    logic s1, s2;
    always_ff @(posedge clk) begin
      s1 <= d[i];
      s2 <= s1;
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/osc_edge_counter.sv
`timescale 1ns/1ps
// Feedback-domain side: free-running edge counter, snapshot on request toggle.
module osc_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             fb_clk,
  input  logic             rst_fb,
  input  logic             req_s,
  output logic [CNT_W-1:0] snap,
  output logic             ack_tgl
);
  logic [CNT_W-1:0] edge_cnt;
  logic             req_seen;

  always_ff @(posedge fb_clk) begin
    if (rst_fb) begin
      edge_cnt <= '0;
      req_seen <= 1'b0;
      snap     <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      edge_cnt <= edge_cnt + 1'b1;
      if (req_s != req_seen) begin
        req_seen <= req_s;
        snap     <= edge_cnt;
        ack_tgl  <= ~ack_tgl;
      end
    end
  end

  AST_ACK_ON_REQ: assert property (@(posedge fb_clk) disable iff (rst_fb)
    (req_s != req_seen) |=> (ack_tgl != $past(ack_tgl))); // R2
endmodule

// File: rtl/window_comparator.sv
`timescale 1ns/1ps
// Reference-domain window timer, count difference, tolerance test, hysteresis.
module window_comparator #(
  parameter int WIN_LEN  = 32,
  parameter int CNT_W    = 16,
  parameter int M_W      = 8,
  parameter int TOL_W    = 8,
  parameter int HIT_RUN  = 3,
  parameter int MISS_RUN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [M_W-1:0]   div_ratio,
  input  logic [TOL_W-1:0] tol,
  input  logic [CNT_W-1:0] snap,
  input  logic             ack_s,
  output logic             req_tgl,
  output logic             freq_locked
);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int HIT_W = $clog2(HIT_RUN + 1);
  localparam int MIS_W = $clog2(MISS_RUN + 1);

  logic [WIN_W-1:0] win_cnt;
  logic             ack_seen, primed;
  logic [CNT_W-1:0] prev_snap;
  logic             res_vld, res_match;
  logic [HIT_W-1:0] hit_run;
  logic [MIS_W-1:0] miss_run;

  logic [CNT_W-1:0] expect_cnt, meas, err, mag;
  logic             ack_evt, in_tol;

  always_comb begin
    expect_cnt = CNT_W'(WIN_LEN) * CNT_W'(div_ratio);
    meas       = snap - prev_snap;
    err        = meas - expect_cnt;
    mag        = err[CNT_W-1] ? (~err + 1'b1) : err;
    in_tol     = (mag <= CNT_W'(tol));
    ack_evt    = (ack_s != ack_seen);
  end

  // window timer and request toggle
  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      req_tgl <= 1'b0;
    end else if (win_cnt == WIN_W'(WIN_LEN - 1)) begin
      win_cnt <= '0;
      req_tgl <= ~req_tgl;
    end else begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  // snapshot capture and window result
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_seen  <= 1'b0;
      primed    <= 1'b0;
      prev_snap <= '0;
      res_vld   <= 1'b0;
      res_match <= 1'b0;
    end else begin
      res_vld <= 1'b0;
      if (ack_evt) begin
        ack_seen  <= ack_s;
        prev_snap <= snap;
        primed    <= 1'b1;
        res_vld   <= primed;
        res_match <= in_tol;
      end
    end
  end

  // hysteresis on consecutive window outcomes
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      hit_run     <= '0;
      miss_run    <= '0;
      freq_locked <= 1'b0;
    end else if (res_vld) begin
      if (res_match) begin
        miss_run <= '0;
        if (hit_run != HIT_W'(HIT_RUN)) hit_run <= hit_run + 1'b1;
        if (hit_run >= HIT_W'(HIT_RUN - 1)) freq_locked <= 1'b1;
      end else begin
        hit_run <= '0;
        if (miss_run != MIS_W'(MISS_RUN)) miss_run <= miss_run + 1'b1;
        if (miss_run >= MIS_W'(MISS_RUN - 1)) freq_locked <= 1'b0;
      end
    end
  end

  AST_LOCK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(freq_locked) |-> $past(res_vld && res_match)); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> !freq_locked); // R12
  AST_DROP_NEEDS_MISS: assert property (@(posedge clk) disable iff (rst)
    $fell(freq_locked) |-> $past(restart || (res_vld && !res_match))); // R9
endmodule

// File: rtl/lock_sequencer.sv
`timescale 1ns/1ps
// Loop handover state machine with registered enables.
module lock_sequencer
  import lock_ctrl_pkg::*;
#(
  parameter int BL_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            freq_locked,
  input  logic            lost_s,
  input  logic [BL_W-1:0] blank_len,
  output logic            restart,
  output logic            freq_en,
  output logic            phase_en,
  output logic            locked,
  output logic [1:0]      status
);
  lock_state_t     state, state_nxt;
  logic [BL_W-1:0] blank_cnt;

  always_comb begin
    state_nxt = state;
    restart   = 1'b0;
    case (state)
      ST_ACQ:   if (freq_locked) state_nxt = ST_HAND;
      ST_HAND:  if (blank_cnt == '0) state_nxt = ST_TRACK;
      ST_TRACK: if (lost_s || !freq_locked) begin
                  state_nxt = ST_ACQ;
                  restart   = 1'b1;
                end
      default:  state_nxt = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ACQ;
      blank_cnt <= '0;
      freq_en   <= 1'b1;
      phase_en  <= 1'b0;
      locked    <= 1'b0;
      status    <= 2'd0;
    end else begin
      state    <= state_nxt;
      freq_en  <= (state_nxt == ST_ACQ);
      phase_en <= (state_nxt == ST_TRACK);
      locked   <= (state_nxt == ST_TRACK);
      status   <= state_nxt;
      if (state == ST_ACQ && state_nxt == ST_HAND)
        blank_cnt <= (blank_len == '0) ? '0 : blank_len - 1'b1;
      else if (blank_cnt != '0)
        blank_cnt <= blank_cnt - 1'b1;
    end
  end

  AST_EN_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(freq_en && phase_en)); // R3
  AST_RST_ACQ: assert property (@(posedge clk)
    $past(rst) |-> (freq_en && !phase_en && !locked)); // R1
  AST_TRACK_VIA_HAND: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_en) |-> $past(status == 2'd1)); // R4
  AST_LOST_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRACK && lost_s) |=> (freq_en && !locked)); // R6
  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (status == 2'd1) |-> (!freq_en && !phase_en)); // R3
endmodule

// File: rtl/freq_phase_lock_ctrl.sv
`timescale 1ns/1ps
module freq_phase_lock_ctrl #(
  parameter int WIN_LEN  = 32,
  parameter int HIT_RUN  = 3,
  parameter int MISS_RUN = 2,
  parameter int CNT_W    = 16,
  parameter int M_W      = 8,
  parameter int TOL_W    = 8,
  parameter int BL_W     = 8
) (
  input  logic             ref_clk,
  input  logic             rst,
  input  logic             fb_clk,
  input  logic [M_W-1:0]   div_ratio,
  input  logic [TOL_W-1:0] tol,
  input  logic [BL_W-1:0]  blank_len,
  input  logic             phase_lost,
  output logic             freq_en,
  output logic             phase_en,
  output logic             locked,
  output logic [1:0]       status
);
  logic             rst_fb, req_tgl, req_s, ack_tgl, ack_s, lost_s;
  logic             freq_locked, restart;
  logic [CNT_W-1:0] snap;

  bit_sync #(.W(1)) u_rst_fb  (.clk(fb_clk),  .d(rst),        .q(rst_fb));
  bit_sync #(.W(1)) u_req_fb  (.clk(fb_clk),  .d(req_tgl),    .q(req_s));
  bit_sync #(.W(1)) u_ack_ref (.clk(ref_clk), .d(ack_tgl),    .q(ack_s));
  bit_sync #(.W(1)) u_lost    (.clk(ref_clk), .d(phase_lost), .q(lost_s));

  osc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .fb_clk(fb_clk), .rst_fb(rst_fb), .req_s(req_s),
    .snap(snap), .ack_tgl(ack_tgl)
  );

  window_comparator #(
    .WIN_LEN(WIN_LEN), .CNT_W(CNT_W), .M_W(M_W), .TOL_W(TOL_W),
    .HIT_RUN(HIT_RUN), .MISS_RUN(MISS_RUN)
  ) u_cmp (
    .clk(ref_clk), .rst(rst), .restart(restart), .div_ratio(div_ratio),
    .tol(tol), .snap(snap), .ack_s(ack_s), .req_tgl(req_tgl),
    .freq_locked(freq_locked)
  );

  lock_sequencer #(.BL_W(BL_W)) u_seq (
    .clk(ref_clk), .rst(rst), .freq_locked(freq_locked), .lost_s(lost_s),
    .blank_len(blank_len), .restart(restart), .freq_en(freq_en),
    .phase_en(phase_en), .locked(locked), .status(status)
  );
endmodule

// File: tb/sim_freq_phase_lock_ctrl.sv
`timescale 1ns/1ps
module sim_freq_phase_lock_ctrl;
  localparam int N = 32, K = 3, J = 2;

  logic ref_clk = 0, fb_clk = 0, rst = 1, phase_lost = 0;
  logic [7:0] div_ratio = 8'd4, tol = 8'd4, blank_len = 8'd6;
  logic freq_en, phase_en, locked;
  logic [1:0] status;
  real fb_half = 0.625;

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;

  always #2.5 ref_clk = ~ref_clk;
  always #(fb_half) fb_clk = ~fb_clk;

  freq_phase_lock_ctrl u0 (
    .ref_clk(ref_clk), .rst(rst), .fb_clk(fb_clk), .div_ratio(div_ratio),
    .tol(tol), .blank_len(blank_len), .phase_lost(phase_lost),
    .freq_en(freq_en), .phase_en(phase_en), .locked(locked), .status(status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  // waits for status==target; returns cycles waited, or -1 on limit
  task automatic wait_st(input int target, input int limit, output int waited);
    waited = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge ref_clk);
      if (status == 2'(target)) begin waited = i; break; end
    end
  endtask

  // per-cycle behavioural model of the state encoding and handover length
  int prev_st = 0, hand_len = 0, hand_exp = 0;
  always @(negedge ref_clk) begin
    cycles++;
    if (!rst && !finished) begin
      chk(!(freq_en && phase_en), "R3", "enables exclusive", int'(phase_en), 0);
      chk(status != 2'd3, "R3", "status code", int'(status), 2);
      chk(freq_en == (status == 2'd0) && phase_en == (status == 2'd2)
          && locked == (status == 2'd2), "R3", "outputs vs status",
          int'({freq_en, phase_en, locked}), int'(status));
      if (int'(status) != prev_st)
        chk((prev_st == 0 && status == 2'd1) || (prev_st == 1 && status == 2'd2)
            || (prev_st == 2 && status == 2'd0), "R4", "transition",
            int'(status), (prev_st + 1) % 3);
      if (status == 2'd1) begin
        if (prev_st != 1) begin
          hand_len = 0;
          hand_exp = (blank_len == 0) ? 1 : int'(blank_len);
        end
        hand_len++;
      end
      if (prev_st == 1 && status == 2'd2)
        chk(hand_len == hand_exp, "R7", "handover length", hand_len, hand_exp);
      prev_st = int'(status);
    end
  end

  always @(negedge ref_clk) begin
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w;
    cyc(4);
    chk(status == 0 && freq_en && !phase_en && !locked, "R1", "in reset",
        int'(status), 0);
    @(negedge ref_clk) rst = 0;
    cyc(1);
    chk(status == 0 && freq_en && !phase_en && !locked, "R1", "after reset",
        int'({freq_en, phase_en}), 2);

    // R5: earliest lock bound
    cyc((K + 1) * N - 2);
    chk(status == 0, "R5", "no lock before K windows", int'(status), 0);
    wait_st(2, 100, w);
    chk(w > 0, "R2", "matched clock locks", int'(status), 2);

    // R6: phase lost in tracking
    cyc(5);
    phase_lost = 1;
    cyc(2);
    chk(status == 2, "R6", "still tracking after 2 edges", int'(status), 2);
    cyc(1);
    chk(status == 0 && freq_en, "R6", "exit after 3 edges", int'(status), 0);
    // R8: held high during acquisition
    for (int i = 0; i < 10; i++) begin
      @(negedge ref_clk);
      if (status != 0 || !freq_en) begin
        chk(0, "R8", "lost ignored in acquire", int'(status), 0);
        break;
      end
    end
    phase_lost = 0;
    cyc((K - 1) * N - 2 - 11);
    chk(status == 0, "R12", "fresh acquisition needed", int'(status), 0);
    wait_st(2, (K + 1) * N + 30, w);
    chk(w > 0, "R12", "relock after lost", int'(status), 2);

    // R8: pulse during handover; R7 with another blank length
    cyc(4);
    blank_len = 8'd9;
    phase_lost = 1; cyc(3); phase_lost = 0;
    wait_st(1, (K + 2) * N + 40, w);
    chk(w > 0, "R8", "enter handover", int'(status), 1);
    phase_lost = 1;
    @(negedge ref_clk) phase_lost = 0;
    wait_st(2, 20, w);
    chk(w > 0, "R8", "handover completes", int'(status), 2);
    cyc(10);
    chk(status == 2, "R8", "tracking holds after pulse", int'(status), 2);

    // R9 / R10: far off frequency
    fb_half = 0.5682;
    cyc(20);
    chk(status == 2, "R9", "single window no drop", int'(status), 2);
    wait_st(0, (J + 1) * N + 20, w);
    chk(w > 0, "R9", "miss run drops lock", int'(status), 0);
    for (int i = 0; i < 300; i++) begin
      @(negedge ref_clk);
      if (status != 0) begin
        chk(0, "R10", "out of tolerance never locks", int'(status), 0);
        break;
      end
    end
    chk(status == 0, "R10", "still acquiring", int'(status), 0);

    // R10: inside tolerance; R7 with blank 0
    blank_len = 8'd0;
    fb_half = 0.615;
    wait_st(2, (K + 3) * N + 30, w);
    chk(w > 0, "R10", "within tolerance locks", int'(status), 2);

    // R11: divide ratio
    blank_len = 8'd3;
    div_ratio = 8'd8;
    wait_st(0, (J + 2) * N + 20, w);
    chk(w > 0, "R11", "ratio change drops lock", int'(status), 0);
    fb_half = 0.3125;
    wait_st(2, (K + 3) * N + 30, w);
    chk(w > 0, "R11", "new ratio locks", int'(status), 2);
    cyc(50);
    chk(status == 2 && locked, "R11", "stays locked", int'(status), 2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule